// File: doc/BRIEF.md
# Dual-Source Output Buffer Interrupt Arbiter

This block sits between two receive channels of a keyboard controller, one carrying keyboard bytes and one carrying auxiliary (pointing device) bytes, and the host-facing side of the controller. Each channel reports a level that is high while it holds a byte for the host. The arbiter merges the two levels into the controller's output-buffer flags, the mirror flags on the output port, and two interrupt lines. When the host reads the data port, it picks which channel supplies the byte.

Keyboard data always has priority. The auxiliary flag, the auxiliary interrupt and the auxiliary read selection are raised only while the auxiliary channel is the sole channel with data. The keyboard interrupt is gated by an enable bit in the mode register and is also masked by the keyboard-disable mode bit. Every output is registered, so a change on a pending input or on the mode register appears on the outputs at the next clock edge. A host data read produces a single-cycle pop pulse aimed only at the channel that supplies the byte.

Top module: `obarb_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, status_o, port_flags_o, irq_kbd_o, irq_aux_o, rd_sel_aux_o and pop_o are all zero.
- R2: Status bit 0 (buffer full) and port flag bit 4 are high exactly when at least one of kbd_pend_i, aux_pend_i was high at the previous clock edge.
- R3: Status bit 5 (auxiliary buffer full) and port flag bit 5 are high only when aux_pend_i was high and kbd_pend_i low at the previous edge. With both pending, bit 5 stays low.
- R4: irq_aux_o is high exactly when the auxiliary channel alone was pending and mode bit 1 was set at the previous edge. Mode bit 4 does not affect it.
- R5: irq_kbd_o is high exactly when kbd_pend_i was high, mode bit 0 set and mode bit 4 clear at the previous edge. The value of aux_pend_i does not affect it.
- R6: rd_sel_aux_o is high only when the auxiliary channel alone was pending. In every other case, including nothing pending, it is low and selects the keyboard channel.
- R7: A one-cycle pulse on rd_i produces, at the next edge, a one-cycle pulse on exactly one bit of pop_o: bit 1 (auxiliary) if rd_sel_aux_o was high when rd_i was sampled, otherwise bit 0 (keyboard).
- R8: All outputs have one cycle of latency. A change on a pending input or on mode_i does not alter any output before the next clock edge.
- R9: Status bits 1 to 4, 6 and 7 and port flag bits 0 to 3, 6 and 7 are always zero. The neighbouring logic fills those positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kbd_pend_i | input | 1 | Keyboard channel holds a byte |
| aux_pend_i | input | 1 | Auxiliary channel holds a byte |
| mode_i | input | 8 | Mode register: bit 0 keyboard interrupt enable, bit 1 auxiliary interrupt enable, bit 4 keyboard disable |
| rd_i | input | 1 | Host data-port read strobe |
| status_o | output | 8 | Status flags: bit 0 buffer full, bit 5 auxiliary buffer full |
| port_flags_o | output | 8 | Output-port mirror: bit 4 buffer full, bit 5 auxiliary buffer full |
| irq_kbd_o | output | 1 | Keyboard interrupt level |
| irq_aux_o | output | 1 | Auxiliary interrupt level |
| rd_sel_aux_o | output | 1 | High: data read takes the auxiliary byte |
| pop_o | output | 2 | Pop pulse: bit 0 keyboard, bit 1 auxiliary |

## Verification
The bench drives both channels pending together. A design that let the auxiliary side win would raise bit 5, assert the auxiliary interrupt, and pop the wrong channel. It sets the keyboard-disable bit with the keyboard interrupt enabled and expects the keyboard interrupt to stay low, and it sets the same bit with only auxiliary data pending and expects the auxiliary interrupt to stay high. A design that applied the disable to both lines would fail one of these cases. It also issues a read with nothing pending, where a wrong design would pop no channel or the auxiliary one. It samples just before each edge to catch outputs that bypass the register stage.

// File: rtl/obarb_pkg.sv
package obarb_pkg;
    localparam int NCH         = 2;
    localparam int CH_KBD      = 0;
    localparam int CH_AUX      = 1;
    localparam int BYTE_W      = 8;
    // mode bit positions
    localparam int MODE_KIRQ   = 0;
    localparam int MODE_AIRQ   = 1;
    localparam int MODE_KDIS   = 4;
    // flag positions decoded by neighbouring logic
    localparam int STAT_FULL   = 0;
    localparam int STAT_AUX    = 5;
    localparam int PORT_FULL   = 4;
    localparam int PORT_AUX    = 5;

    typedef struct packed {
        logic             full;
        logic             aux_only;
        logic             irq_kbd;
        logic             irq_aux;
        logic             sel_aux;
        logic [NCH-1:0]   pop;
    } obarb_state_t;
endpackage

// File: rtl/obarb_select.sv
module obarb_select
    import obarb_pkg::*;
(
    input  logic [NCH-1:0] pend_i,
    output logic           full_o,
    output logic           kbd_o,
    output logic           aux_only_o
);
    always_comb begin
        full_o     = |pend_i;
        kbd_o      = pend_i[CH_KBD];
        aux_only_o = pend_i[CH_AUX] & ~pend_i[CH_KBD];
    end
endmodule

// File: rtl/obarb_irq_gate.sv
module obarb_irq_gate
    import obarb_pkg::*;
(
    input  logic kirq_en_i,
    input  logic airq_en_i,
    input  logic kdis_i,
    input  logic kbd_i,
    input  logic aux_only_i,
    output logic irq_kbd_o,
    output logic irq_aux_o
);
    always_comb begin
        irq_kbd_o = kbd_i & kirq_en_i & ~kdis_i;
        irq_aux_o = aux_only_i & airq_en_i;
    end
endmodule

// File: rtl/obarb_pop.sv
module obarb_pop
    import obarb_pkg::*;
(
    input  logic           rd_i,
    input  logic           sel_aux_i,
    output logic [NCH-1:0] pop_o
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_pop
        if (ch == CH_AUX) begin : g_aux
            assign pop_o[ch] = rd_i & sel_aux_i;
        end else begin : g_kbd
            assign pop_o[ch] = rd_i & ~sel_aux_i;
        end
    end
endmodule

// File: rtl/obarb_top.sv
module obarb_top
    import obarb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              kbd_pend_i,
    input  logic              aux_pend_i,
    input  logic [BYTE_W-1:0] mode_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] port_flags_o,
    output logic              irq_kbd_o,
    output logic              irq_aux_o,
    output logic              rd_sel_aux_o,
    output logic [NCH-1:0]    pop_o
);
    obarb_state_t state_d, state_q;

    logic [NCH-1:0] pend_w;
    logic           full_w, kbd_w, aux_only_w;
    logic           irq_kbd_w, irq_aux_w;
    logic [NCH-1:0] pop_w;
    logic           mode_unused;

    assign mode_unused = ^mode_i;

    always_comb begin
        pend_w         = '0;
        pend_w[CH_KBD] = kbd_pend_i;
        pend_w[CH_AUX] = aux_pend_i;
    end

    obarb_select u_select (
        .pend_i     (pend_w),
        .full_o     (full_w),
        .kbd_o      (kbd_w),
        .aux_only_o (aux_only_w)
    );

    obarb_irq_gate u_irq_gate (
        .kirq_en_i  (mode_i[MODE_KIRQ]),
        .airq_en_i  (mode_i[MODE_AIRQ]),
        .kdis_i     (mode_i[MODE_KDIS]),
        .kbd_i      (kbd_w),
        .aux_only_i (aux_only_w),
        .irq_kbd_o  (irq_kbd_w),
        .irq_aux_o  (irq_aux_w)
    );

    obarb_pop u_pop (
        .rd_i      (rd_i),
        .sel_aux_i (state_q.sel_aux),
        .pop_o     (pop_w)
    );

    always_comb begin
        state_d          = state_q;
        state_d.full     = full_w;
        state_d.aux_only = aux_only_w;
        state_d.irq_kbd  = irq_kbd_w;
        state_d.irq_aux  = irq_aux_w;
        state_d.sel_aux  = aux_only_w;
        state_d.pop      = pop_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        status_o                = '0;
        status_o[STAT_FULL]     = state_q.full;
        status_o[STAT_AUX]      = state_q.aux_only;
        port_flags_o            = '0;
        port_flags_o[PORT_FULL] = state_q.full;
        port_flags_o[PORT_AUX]  = state_q.aux_only;
        irq_kbd_o               = state_q.irq_kbd;
        irq_aux_o               = state_q.irq_aux;
        rd_sel_aux_o            = state_q.sel_aux;
        pop_o                   = state_q.pop;
    end
endmodule

// File: rtl/obarb_checker.sv
module obarb_checker
    import obarb_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              kbd_pend_i,
    input logic              aux_pend_i,
    input logic [BYTE_W-1:0] mode_i,
    input logic              rd_i,
    input logic [BYTE_W-1:0] status_o,
    input logic [BYTE_W-1:0] port_flags_o,
    input logic              irq_kbd_o,
    input logic              irq_aux_o,
    input logic              rd_sel_aux_o,
    input logic [NCH-1:0]    pop_o
);
    a_r2_full_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kbd_pend_i || aux_pend_i) |=> (status_o[STAT_FULL] && port_flags_o[PORT_FULL]));

    a_r2_full_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!kbd_pend_i && !aux_pend_i) |=> (!status_o[STAT_FULL] && !port_flags_o[PORT_FULL]));

    a_r3_kbd_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kbd_pend_i |=> (!status_o[STAT_AUX] && !port_flags_o[PORT_AUX]));

    a_r4_aux_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_aux_o |-> status_o[STAT_AUX]);

    a_r5_kbd_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i[MODE_KDIS] || !kbd_pend_i) |=> !irq_kbd_o);

    a_r6_sel_follows_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_sel_aux_o |-> (status_o[STAT_AUX] && status_o[STAT_FULL]));

    a_r7_pop_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(pop_o));

    a_r7_pop_aux: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && rd_sel_aux_o) |=> pop_o[CH_AUX]);

    a_r7_pop_kbd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !rd_sel_aux_o) |=> pop_o[CH_KBD]);

    a_r7_no_stray_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> (pop_o == '0));
endmodule

bind obarb_top obarb_checker u_obarb_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .kbd_pend_i   (kbd_pend_i),
    .aux_pend_i   (aux_pend_i),
    .mode_i       (mode_i),
    .rd_i         (rd_i),
    .status_o     (status_o),
    .port_flags_o (port_flags_o),
    .irq_kbd_o    (irq_kbd_o),
    .irq_aux_o    (irq_aux_o),
    .rd_sel_aux_o (rd_sel_aux_o),
    .pop_o        (pop_o)
);

// File: tb/test_obarb_top.sv
module test_obarb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd = 1'b0;
    logic       aux = 1'b0;
    logic [7:0] mode = 8'h00;
    logic       rd = 1'b0;
    logic [7:0] status, portf;
    logic       irqk, irqa, sel;
    logic [1:0] pop;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    obarb_top i_obarb_top (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .kbd_pend_i   (kbd),
        .aux_pend_i   (aux),
        .mode_i       (mode),
        .rd_i         (rd),
        .status_o     (status),
        .port_flags_o (portf),
        .irq_kbd_o    (irqk),
        .irq_aux_o    (irqa),
        .rd_sel_aux_o (sel),
        .pop_o        (pop)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, got, exp);
        end
    endtask

    // Expected outputs, computed from the requirements.
    task automatic check_all(input string req, input logic k, input logic a,
                             input logic [7:0] m);
        logic       alone;
        logic [7:0] es, ep;
        alone = a & ~k;
        es = 8'h00; ep = 8'h00;
        es[0] = k | a; es[5] = alone;
        ep[4] = k | a; ep[5] = alone;
        check(req, "status", status, es);
        check(req, "portflags", portf, ep);
        check(req, "irq_kbd", {7'd0, irqk}, {7'd0, k & m[0] & ~m[4]});
        check(req, "irq_aux", {7'd0, irqa}, {7'd0, alone & m[1]});
        check(req, "rd_sel", {7'd0, sel}, {7'd0, alone});
    endtask

    task automatic apply(input logic k, input logic a, input logic [7:0] m);
        @(negedge clk);
        kbd = k; aux = a; mode = m;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "status", status, 8'h00);
        check("R1", "portflags", portf, 8'h00);
        check("R1", "irqs", {6'd0, irqk, irqa}, 8'h00);
        check("R1", "sel_pop", {5'd0, sel, pop}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "status after release", status, 8'h00);
        check("R1", "pop after release", {6'd0, pop}, 8'h00);
    endtask

    task automatic t_single_sources();
        apply(1'b0, 1'b0, 8'h03); check_all("R2 idle", 1'b0, 1'b0, 8'h03);
        apply(1'b1, 1'b0, 8'h03); check_all("R2 R5 kbd", 1'b1, 1'b0, 8'h03);
        apply(1'b0, 1'b1, 8'h03); check_all("R3 R4 R6 aux", 1'b0, 1'b1, 8'h03);
        check("R9", "unused status bits", status & 8'hDE, 8'h00);
        check("R9", "unused port bits", portf & 8'hCF, 8'h00);
    endtask

    task automatic t_priority();
        apply(1'b1, 1'b1, 8'h03); check_all("R3 R6 both", 1'b1, 1'b1, 8'h03);
        check("R3", "aux flag with both", {7'd0, status[5]}, 8'h00);
    endtask

    task automatic t_gating();
        apply(1'b1, 1'b0, 8'h13); check_all("R5 kdis", 1'b1, 1'b0, 8'h13);
        apply(1'b1, 1'b0, 8'h02); check_all("R5 kirq off", 1'b1, 1'b0, 8'h02);
        apply(1'b1, 1'b1, 8'h01); check_all("R5 both kirq", 1'b1, 1'b1, 8'h01);
        apply(1'b0, 1'b1, 8'h01); check_all("R4 airq off", 1'b0, 1'b1, 8'h01);
        apply(1'b0, 1'b1, 8'h12); check_all("R4 kdis no effect", 1'b0, 1'b1, 8'h12);
    endtask

    task automatic t_latency();
        apply(1'b0, 1'b0, 8'h03);
        @(negedge clk);
        kbd = 1'b0; aux = 1'b1;
        @(posedge clk); #1;
        check("R8", "irq_aux after edge", {7'd0, irqa}, 8'h01);
        @(negedge clk);
        mode = 8'h01;
        #(CLK_PERIOD/2 - 1);
        check("R8", "irq_aux before edge", {7'd0, irqa}, 8'h01);
        @(posedge clk); #1;
        check("R8", "irq_aux after mode edge", {7'd0, irqa}, 8'h00);
    endtask

    task automatic read_pulse(input string req, input logic [1:0] exp_pop);
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check(req, "pop pulse", {6'd0, pop}, {6'd0, exp_pop});
        @(negedge clk);
        check(req, "pop ends", {6'd0, pop}, 8'h00);
    endtask

    task automatic t_pop();
        apply(1'b0, 1'b1, 8'h03); read_pulse("R7 aux pop", 2'b10);
        apply(1'b1, 1'b0, 8'h03); read_pulse("R7 kbd pop", 2'b01);
        apply(1'b1, 1'b1, 8'h03); read_pulse("R7 R6 both pop", 2'b01);
        apply(1'b0, 1'b0, 8'h03); read_pulse("R6 empty pop", 2'b01);
    endtask

    initial begin
        #(CLK_PERIOD * 3 + 2);
        t_reset();
        t_single_sources();
        t_priority();
        t_gating();
        t_latency();
        t_pop();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule